// File: doc/BRIEF.md
# Dual-Core Reset Fetch Address Selector

This block works out where each of two processor cores fetches its first instruction after reset. After reset is released it counts rising clock edges. On a fixed edge it captures an external boot-mode pin and then holds that value. The captured pin picks one of two programmed option addresses for each core. The option addresses come in as static inputs.

Each picked address is classified against a small built-in memory map. An address that falls in no mapped region gets a fixed per-core default, and that default depends on the pin value. A separate input requests the strictest protection level. Under that level only flash or system-memory addresses are accepted, and anything else is replaced by the core's flash default.

The two resolved addresses are registered one cycle after the pin is captured. A valid flag rises with them and stays high until the next reset.

Top module: `dual_boot_addr_sel`

## Requirements
- R1: While reset is asserted, and until the addresses are resolved, both boot addresses read 0x0000_0000 and the valid flag is low.
- R2: The boot pin is captured on the 4th rising clock edge after reset is released. Pin values present at any other edge have no effect on the outputs.
- R3: A captured pin of 0 selects each core's option-0 address, and a captured pin of 1 selects each core's option-1 address.
- R4: Any address above 0x3FFF_FFFF is treated as unmapped.
- R5: The mapped regions, with inclusive limits, are as follows. Flash is 0x0800_0000–0x081F_FFFF. System memory is 0x1FF0_0000–0x1FF1_FFFF. RAM is made up of four ranges: 0x0000_0000–0x0000_FFFF, 0x2000_0000–0x2001_FFFF, 0x1000_0000–0x1004_7FFF and 0x2400_0000–0x2407_FFFF. Every other address is unmapped.
- R6: Without protection, an unmapped choice falls back to a default that depends on the core and the pin. With pin 0, core A gets 0x0800_0000 and core B gets 0x0810_0000. With pin 1, core A gets 0x1FF0_0000 and core B gets 0x1000_0000.
- R7: With protection active, a flash or system-memory choice is passed through unchanged.
- R8: With protection active, a RAM or unmapped choice forces core A to 0x0800_0000 and core B to 0x0810_0000, whatever the pin value.
- R9: The valid flag rises on the 5th rising edge after reset release, which is the cycle after capture, together with the addresses. It then stays high and the addresses stay stable until reset.
- R10: An asynchronous reset in mid-session clears the outputs at once. A new capture sequence then follows from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin | input | 1 | External boot-mode pin |
| prot_max | input | 1 | Strictest protection level active |
| opt_a_add0 | input | 32 | Core A option-0 address |
| opt_a_add1 | input | 32 | Core A option-1 address |
| opt_b_add0 | input | 32 | Core B option-0 address |
| opt_b_add1 | input | 32 | Core B option-1 address |
| boot_addr_a | output | 32 | Resolved fetch address, core A |
| boot_addr_b | output | 32 | Resolved fetch address, core B |
| boot_valid | output | 1 | Addresses resolved and held |

## Verification
The bench builds the block with its default parameters: a 32-bit address and capture on the 4th edge. With these, the bench can drive the pin to a different value on edges 3, 4 and 5, which shows that only the 4th edge counts. The stimulus places option addresses on region limits, one address past a limit, and addresses above 0x3FFF_FFFF. It runs each of these under both pin values and both protection settings, so that the pin-dependent defaults are told apart from the forced protection default. A reset in the middle of a session restarts the edge count from the new release.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_FLASH = 2'd1,
    RK_SYS   = 2'd2,
    RK_RAM   = 2'd3
  } region_kind_t;

  typedef struct packed {
    logic [31:0]  base;
    logic [31:0]  limit;
    region_kind_t kind;
  } region_t;

  localparam int NUM_CORES   = 2;
  localparam int NUM_REGIONS = 6;

  // Memory map entry by index; limits are inclusive
  function automatic region_t region_at(input int idx);
    region_t r;
    case (idx)
      0:       r = '{base: 32'h0800_0000, limit: 32'h081F_FFFF, kind: RK_FLASH};
      1:       r = '{base: 32'h1FF0_0000, limit: 32'h1FF1_FFFF, kind: RK_SYS};
      2:       r = '{base: 32'h0000_0000, limit: 32'h0000_FFFF, kind: RK_RAM};
      3:       r = '{base: 32'h2000_0000, limit: 32'h2001_FFFF, kind: RK_RAM};
      4:       r = '{base: 32'h1000_0000, limit: 32'h1004_7FFF, kind: RK_RAM};
      default: r = '{base: 32'h2400_0000, limit: 32'h2407_FFFF, kind: RK_RAM};
    endcase
    return r;
  endfunction

  // Classify an address; nothing above 0x3FFF_FFFF is in the table
  function automatic region_kind_t classify(input logic [31:0] addr);
    region_kind_t k;
    region_t      r;
    k = RK_NONE;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      r = region_at(i);
      if (addr >= r.base && addr <= r.limit) k = r.kind;
    end
    return k;
  endfunction

  // Fallback address per core and option when the choice is unmapped
  function automatic logic [31:0] unmapped_default(input int core, input logic opt);
    logic [31:0] a;
    if (core == 0) a = opt ? 32'h1FF0_0000 : 32'h0800_0000;
    else           a = opt ? 32'h1000_0000 : 32'h0810_0000;
    return a;
  endfunction

  // Forced address per core under the strictest protection
  function automatic logic [31:0] protected_default(input int core);
    return (core == 0) ? 32'h0800_0000 : 32'h0810_0000;
  endfunction

endpackage

// File: rtl/boot_pin_capture.sv
module boot_pin_capture #(
  parameter int SAMPLE_EDGE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_q,
  output logic captured
);
  localparam int CNT_W = $clog2(SAMPLE_EDGE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_EDGE);
  localparam logic [CNT_W-1:0] TAKE = CNT_W'(SAMPLE_EDGE - 1);

  logic [CNT_W-1:0] edge_cnt;
  logic             sample_now;

  assign sample_now = (edge_cnt == TAKE);
  assign captured   = (edge_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      pin_q    <= 1'b0;
    end else begin
      if (!captured) edge_cnt <= edge_cnt + 1'b1;
      if (sample_now) pin_q <= pin_in;
    end
  end

  p_count_saturates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> captured);
  p_pin_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> $stable(pin_q));
  p_capture_follows_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |=> captured);

endmodule

// File: rtl/boot_addr_resolve.sv
module boot_addr_resolve
  import boot_sel_pkg::*;
#(
  parameter int CORE_IDX = 0
) (
  input  logic        pin,
  input  logic        prot_max,
  input  logic [31:0] opt0,
  input  logic [31:0] opt1,
  output logic [31:0] addr_out,
  output logic        fell_back
);
  localparam logic [31:0] DFLT0 = unmapped_default(CORE_IDX, 1'b0);
  localparam logic [31:0] DFLT1 = unmapped_default(CORE_IDX, 1'b1);
  localparam logic [31:0] PDFLT = protected_default(CORE_IDX);

  logic [31:0]  picked;
  region_kind_t kind;
  logic         accept;

  always_comb begin
    picked = pin ? opt1 : opt0;
    kind   = classify(picked);
    if (prot_max) accept = (kind == RK_FLASH) || (kind == RK_SYS);
    else          accept = (kind != RK_NONE);
    fell_back = !accept;
    if (accept)        addr_out = picked;
    else if (prot_max) addr_out = PDFLT;
    else               addr_out = pin ? DFLT1 : DFLT0;
  end

endmodule

// File: rtl/dual_boot_addr_sel.sv
module dual_boot_addr_sel
  import boot_sel_pkg::*;
#(
  parameter int SAMPLE_EDGE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_pin,
  input  logic        prot_max,
  input  logic [31:0] opt_a_add0,
  input  logic [31:0] opt_a_add1,
  input  logic [31:0] opt_b_add0,
  input  logic [31:0] opt_b_add1,
  output logic [31:0] boot_addr_a,
  output logic [31:0] boot_addr_b,
  output logic        boot_valid
);
  logic        pin_q;
  logic        captured;
  logic        load_evt;
  logic [31:0] opt0   [NUM_CORES];
  logic [31:0] opt1   [NUM_CORES];
  logic [31:0] res    [NUM_CORES];
  logic [31:0] addr_q [NUM_CORES];
  logic [NUM_CORES-1:0] fell_back;

  assign opt0[0] = opt_a_add0;
  assign opt1[0] = opt_a_add1;
  assign opt0[1] = opt_b_add0;
  assign opt1[1] = opt_b_add1;

  boot_pin_capture #(.SAMPLE_EDGE(SAMPLE_EDGE)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (boot_pin),
    .pin_q    (pin_q),
    .captured (captured)
  );

  assign load_evt = captured && !boot_valid;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    boot_addr_resolve #(.CORE_IDX(k)) u_res (
      .pin       (pin_q),
      .prot_max  (prot_max),
      .opt0      (opt0[k]),
      .opt1      (opt1[k]),
      .addr_out  (res[k]),
      .fell_back (fell_back[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr_q[k] <= '0;
      else if (load_evt) addr_q[k] <= res[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        boot_valid <= 1'b0;
    else if (load_evt) boot_valid <= 1'b1;
  end

  assign boot_addr_a = addr_q[0];
  assign boot_addr_b = addr_q[1];

  p_valid_after_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> boot_valid);
  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_valid |=> boot_valid);
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_valid |=> ($stable(boot_addr_a) && $stable(boot_addr_b)));
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_valid |-> (boot_addr_a == '0 && boot_addr_b == '0));
  p_mapped_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_valid |-> (classify(boot_addr_a) != RK_NONE && classify(boot_addr_b) != RK_NONE));
  p_prot_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_valid && prot_max) |->
      (classify(boot_addr_a) inside {RK_FLASH, RK_SYS} &&
       classify(boot_addr_b) inside {RK_FLASH, RK_SYS}));

endmodule

// File: tb/tb_dual_boot_addr_sel.sv
module tb_dual_boot_addr_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin = 1'b0;
  logic        prot_max = 1'b0;
  logic [31:0] opt_a_add0 = '0, opt_a_add1 = '0, opt_b_add0 = '0, opt_b_add1 = '0;
  logic [31:0] boot_addr_a, boot_addr_b;
  logic        boot_valid;

  int total = 0;
  int bad   = 0;
  string cur_req = "R1";

  // model state
  int          m_edges = 0;
  logic        m_pin = 1'b0;
  logic        m_valid = 1'b0;
  logic [31:0] m_a = '0, m_b = '0;

  always #4 clk = ~clk;

  dual_boot_addr_sel dut (
    .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .prot_max(prot_max),
    .opt_a_add0(opt_a_add0), .opt_a_add1(opt_a_add1),
    .opt_b_add0(opt_b_add0), .opt_b_add1(opt_b_add1),
    .boot_addr_a(boot_addr_a), .boot_addr_b(boot_addr_b), .boot_valid(boot_valid)
  );

  // 0 none, 1 flash, 2 system, 3 ram
  function automatic int m_kind(input logic [31:0] a);
    if (a > 32'h3FFF_FFFF) return 0;
    if (a >= 32'h0800_0000 && a < 32'h0820_0000) return 1;
    if (a >= 32'h1FF0_0000 && a < 32'h1FF2_0000) return 2;
    if (a < 32'h0001_0000) return 3;
    if (a >= 32'h1000_0000 && a < 32'h1004_8000) return 3;
    if (a >= 32'h2000_0000 && a < 32'h2002_0000) return 3;
    if (a >= 32'h2400_0000 && a < 32'h2408_0000) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] m_resolve(input bit core_b, input logic pin,
                                            input logic prot, input logic [31:0] o0,
                                            input logic [31:0] o1);
    logic [31:0] p;
    int k;
    p = pin ? o1 : o0;
    k = m_kind(p);
    if (prot) begin
      if (k == 1 || k == 2) return p;
      return core_b ? 32'h0810_0000 : 32'h0800_0000;
    end
    if (k != 0) return p;
    case ({core_b, pin})
      2'b00: return 32'h0800_0000;
      2'b10: return 32'h0810_0000;
      2'b01: return 32'h1FF0_0000;
      default: return 32'h1000_0000;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock reference model and comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges = 0; m_pin = 1'b0; m_valid = 1'b0; m_a = '0; m_b = '0;
    end else begin
      if (m_edges < 10) m_edges++;
      if (m_edges == 4) m_pin = boot_pin;
      if (m_edges == 5) begin
        m_valid = 1'b1;
        m_a = m_resolve(1'b0, m_pin, prot_max, opt_a_add0, opt_a_add1);
        m_b = m_resolve(1'b1, m_pin, prot_max, opt_b_add0, opt_b_add1);
      end
    end
    #3;
    check(cur_req, "valid", {31'b0, boot_valid}, {31'b0, m_valid});
    check(cur_req, "addr_a", boot_addr_a, m_a);
    check(cur_req, "addr_b", boot_addr_b, m_b);
  end

  // pat bit k is the pin level seen by edge k+1 after release
  task automatic run(input string req, input logic [9:0] pat, input logic prot,
                     input logic [31:0] a0, input logic [31:0] a1,
                     input logic [31:0] b0, input logic [31:0] b1);
    @(negedge clk);
    rst_n = 1'b0;
    cur_req = "R1";
    opt_a_add0 = a0; opt_a_add1 = a1; opt_b_add0 = b0; opt_b_add1 = b1;
    prot_max = prot;
    @(negedge clk);
    check("R1", "valid in reset", {31'b0, boot_valid}, 32'd0);
    check("R1", "addr_a in reset", boot_addr_a, 32'd0);
    @(negedge clk);
    boot_pin = pat[0];
    rst_n = 1'b1;
    cur_req = req;
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      boot_pin = pat[i];
    end
  endtask

  initial begin
    #160000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 R3: pin 0 only on edge 4, flash addresses pass
    run("R2", 10'b11_1111_0111, 1'b0, 32'h0800_0400, 32'h2000_0000, 32'h0810_0000, 32'h1000_0000);
    check("R3", "pin0 core A", boot_addr_a, 32'h0800_0400);
    check("R3", "pin0 core B", boot_addr_b, 32'h0810_0000);
    // R2 R3 R5: pin 1 only on edge 4, RAM addresses pass
    run("R3", 10'b00_0000_1000, 1'b0, 32'h0800_0000, 32'h2001_FFFF, 32'h0810_0000, 32'h2400_0000);
    check("R3", "pin1 core A", boot_addr_a, 32'h2001_FFFF);
    check("R5", "pin1 core B", boot_addr_b, 32'h2400_0000);
    // R6 R4: unmapped with pin 0
    run("R6", 10'b00_0000_0000, 1'b0, 32'h0820_0000, 32'h0, 32'h5000_0000, 32'h0);
    check("R5", "past flash limit", boot_addr_a, 32'h0800_0000);
    check("R4", "above range core B", boot_addr_b, 32'h0810_0000);
    // R6 R4: unmapped with pin 1
    run("R6", 10'b11_1111_1111, 1'b0, 32'h0, 32'h3000_0000, 32'h0, 32'hFFFF_FFF0);
    check("R6", "pin1 default A", boot_addr_a, 32'h1FF0_0000);
    check("R6", "pin1 default B", boot_addr_b, 32'h1000_0000);
    // R7 R8: protection, pin 1, system passes and RAM forced
    run("R8", 10'b11_1111_1111, 1'b1, 32'h0, 32'h1FF1_FFFF, 32'h0, 32'h1000_0000);
    check("R7", "prot sys passes", boot_addr_a, 32'h1FF1_FFFF);
    check("R8", "prot ram forced B", boot_addr_b, 32'h0810_0000);
    // R8: protection, unmapped with pin 1 forces flash default, not system
    run("R8", 10'b11_1111_1111, 1'b1, 32'h0, 32'h4000_0000, 32'h0, 32'h081F_FFFF);
    check("R8", "prot unmapped A", boot_addr_a, 32'h0800_0000);
    check("R7", "prot flash passes B", boot_addr_b, 32'h081F_FFFF);
    // R8: protection, pin 0, ITCM forced
    run("R8", 10'b00_0000_0000, 1'b1, 32'h0000_1000, 32'h0, 32'h0810_2000, 32'h0);
    check("R8", "prot itcm forced A", boot_addr_a, 32'h0800_0000);
    check("R7", "prot flash B", boot_addr_b, 32'h0810_2000);
    // R9: valid stays and address holds while pin toggles
    check("R9", "valid held", {31'b0, boot_valid}, 32'd1);
    // R10: mid-session reset, then a shortened session
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", "async clear valid", {31'b0, boot_valid}, 32'd0);
    check("R10", "async clear A", boot_addr_a, 32'd0);
    run("R10", 10'b11_0101_1010, 1'b0, 32'h1004_7FFF, 32'h0000_FFFF, 32'h1004_8000, 32'h0001_0000);
    check("R10", "restart pin1 A", boot_addr_a, 32'h0000_FFFF);
    check("R6", "restart pin1 B unmapped", boot_addr_b, 32'h1000_0000);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // R9 timing: valid low right after edge 4, high right after edge 5
  initial begin
    @(posedge rst_n);
    repeat (4) @(posedge clk);
    #3;
    check("R9", "valid low after edge 4", {31'b0, boot_valid}, 32'd0);
    @(posedge clk);
    #3;
    check("R9", "valid high after edge 5", {31'b0, boot_valid}, 32'd1);
  end

endmodule